// File: doc/BRIEF.md
# Instruction Operand Wakeup Tracker

This block follows a single in-flight instruction through an out-of-order timing model, from the moment it is dispatched until its execution latency has elapsed. It keeps one read tracker per source operand and one counter for the destination write. It reports the lifecycle stage, whether the instruction may issue, how many execution cycles remain, and the signed number of cycles left before the destination write completes.

Source reads wake up through notifications. Each notification carries a producer's remaining latency and a signed read-advance. A read may wait on several producers; it keeps the largest delay it has been told about and starts counting only when the last producer has reported. A destination that only partly overwrites a register adds a second gate: the instruction may not become ready until the older write it merges with is known and close enough to finishing.

There are five stages. ST_EMPTY (code 0) moves to ST_WAITING (1) on dispatch, or straight to ST_READY (2) when nothing is outstanding. ST_WAITING moves to ST_READY on a tick that leaves everything satisfied. ST_READY moves to ST_RUNNING (3) on issue, or to ST_DONE (4) when the latency is zero. ST_RUNNING moves to ST_DONE on the tick that takes the execution count to zero. ST_DONE is left only by reset.

Top module: `op_wakeup_tracker`

## Requirements
- R1: After reset, stage is 0 (ST_EMPTY), ready is 0, exec_left is 0, wr_left is -1 (all ones, meaning unknown), src_ready is all zero and proto_err is 0.
- R2: A dispatch in ST_EMPTY latches the token, the maximum latency and the partial flag, and loads each source's pending-write count from disp_pend (slot s in bits s*3 to s*3+2). A source with a count of 0 is ready at once. If every source is then ready and the partial condition of R5 holds, the stage becomes ST_READY in that same cycle. Otherwise it becomes ST_WAITING.
- R3: A notification sets the delay d = max(0, note_lat - note_adv), where note_adv is two's complement. When it is the slot's last pending write, the slot's remaining count loads the accumulated maximum. With a single pending write, the instruction then reaches ST_READY after max(1, d) ticks. src_ready for that slot goes to 1 right after the notification only when the loaded count is 0.
- R4: While a slot still has pending writes, each notification lowers the count by one and keeps the largest delay seen so far. A tick lowers that accumulated largest delay by one when it is nonzero.
- R5: With the partial flag set, readiness also needs older_left to differ from -1 and, read as an unsigned number, to be strictly less than the maximum latency. Negative counts therefore never qualify. This is evaluated at dispatch and on every tick in ST_WAITING.
- R6: An issue in ST_READY loads exec_left and wr_left with the maximum latency and enters ST_RUNNING. With a latency of 0 it enters ST_DONE directly.
- R7: Each tick in ST_RUNNING lowers exec_left and wr_left by one. The stage becomes ST_DONE when exec_left reaches 0.
- R8: A tick in ST_EMPTY, ST_READY or ST_DONE changes no output.
- R9: A dispatch outside ST_EMPTY, an issue outside ST_READY, or a notification outside ST_WAITING or to a slot with no pending write sets proto_err. proto_err stays set until reset, and the tracker state is left unchanged.
- R10: When more than one of disp_valid, issue_valid, tick and note_valid is high in one cycle, proto_err is set and none of the events is applied.
- R11: ready is 1 exactly when the stage is ST_READY, and ST_READY is reached only with every source ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_token | input | TOKW | Retire-unit token stored at dispatch |
| disp_lat | input | LATW | Maximum latency of the instruction |
| disp_partial | input | 1 | Destination is a partial register write |
| disp_pend | input | NSRC*PCW | Pending producer-write count per source |
| older_left | input | CW | Live remaining cycles of the older write (signed, -1 unknown) |
| issue_valid | input | 1 | Issue strobe |
| tick | input | 1 | One model cycle elapses |
| note_valid | input | 1 | Producer write-start notification strobe |
| note_slot | input | SLOTW | Source slot the notification targets |
| note_lat | input | LATW | Producer remaining latency |
| note_adv | input | LATW | Signed read-advance |
| stage | output | 3 | Lifecycle stage code |
| ready | output | 1 | Instruction may issue |
| exec_left | output | LATW | Remaining execution cycles |
| wr_left | output | CW | Signed remaining cycles of the destination write |
| token | output | TOKW | Stored retire token |
| src_ready | output | NSRC | Per-source ready flags |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The bench builds the tracker with its defaults: two sources, 8-bit latencies, a 16-bit write counter and 3-bit pending counts. Three pending writes fit in one slot, so the running maximum and the tick-while-pending decrement are both reachable. Signed 8-bit read-advance values let the vector table reach delays that are clamped to zero as well as delays stretched past the latency. A 16-bit older-write input lets negative counts show the unsigned-compare behaviour of the partial-write gate.

// File: rtl/owt_pkg.sv
package owt_pkg;

    typedef enum logic [2:0] {
        ST_EMPTY   = 3'd0,
        ST_WAITING = 3'd1,
        ST_READY   = 3'd2,
        ST_RUNNING = 3'd3,
        ST_DONE    = 3'd4
    } stage_e;

endpackage

// File: rtl/owt_read_slot.sv
module owt_read_slot #(
    parameter int LATW = 8,
    parameter int PCW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PCW-1:0]  load_pend,
    input  logic            note,
    input  logic [LATW-1:0] note_lat,
    input  logic [LATW-1:0] note_adv,
    input  logic            tick,
    output logic            pend_nz,
    output logic            rdy_q,
    output logic            rdy_nxt
);
    localparam int DLYW = LATW + 1;
    localparam logic [DLYW-1:0] SENT = '1;

    logic [PCW-1:0]  pend_q, pend_n;
    logic [DLYW-1:0] tot_q, tot_n;
    logic [DLYW-1:0] left_q, left_n;
    logic            rdy_n;

    logic signed [LATW+1:0] diff;
    logic [DLYW-1:0]        dly;
    logic [DLYW-1:0]        mx;

    // delay = max(0, latency - read advance), advance is signed
    always_comb begin
        diff = $signed({2'b00, note_lat})
             - $signed({note_adv[LATW-1], note_adv[LATW-1], note_adv});
        dly  = diff[LATW+1] ? '0 : diff[DLYW-1:0];
        mx   = (dly > tot_q) ? dly : tot_q;
    end

    always_comb begin
        pend_n = pend_q;
        tot_n  = tot_q;
        left_n = left_q;
        rdy_n  = rdy_q;
        if (load) begin
            pend_n = load_pend;
            tot_n  = '0;
            if (load_pend == '0) begin
                left_n = '0;
                rdy_n  = 1'b1;
            end else begin
                left_n = SENT;
                rdy_n  = 1'b0;
            end
        end else if (note) begin
            pend_n = pend_q - 1'b1;
            tot_n  = mx;
            if (pend_q == PCW'(1)) begin
                left_n = mx;
                rdy_n  = (mx == '0);
            end
        end else if (tick) begin
            if (pend_q != '0 && tot_q != '0) begin
                tot_n = tot_q - 1'b1;
            end else if (left_q != SENT && left_q != '0) begin
                left_n = left_q - 1'b1;
                rdy_n  = (left_q == DLYW'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            tot_q  <= '0;
            left_q <= SENT;
            rdy_q  <= 1'b0;
        end else begin
            pend_q <= pend_n;
            tot_q  <= tot_n;
            left_q <= left_n;
            rdy_q  <= rdy_n;
        end
    end

    assign pend_nz = (pend_q != '0);
    assign rdy_nxt = rdy_n;

    // R4: a read with producers outstanding has no known count yet
    p_wait_unknown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q != '0) |-> (left_q == SENT));

    // R3: a known count never grows except through a reload
    p_left_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && pend_q == '0 && left_q != SENT) |=> (left_q <= $past(left_q)));

endmodule

// File: rtl/owt_write_ctr.sv
module owt_write_ctr #(
    parameter int LATW = 8,
    parameter int CW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [LATW-1:0]      load_val,
    input  logic                 dec,
    output logic signed [CW-1:0] wr_q
);
    localparam logic signed [CW-1:0] UNKNOWN = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= UNKNOWN;
        end else if (load) begin
            wr_q <= $signed(CW'(load_val));
        end else if (dec && wr_q != UNKNOWN) begin
            wr_q <= wr_q - 1'b1;
        end
    end

    // R7: the write count only moves down once known
    p_wr_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && wr_q != UNKNOWN) |=> ($signed(wr_q) <= $signed($past(wr_q))));

endmodule

// File: rtl/owt_stage_ctl.sv
module owt_stage_ctl
    import owt_pkg::*;
#(
    parameter int LATW = 8,
    parameter int CW   = 16,
    parameter int TOKW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            disp,
    input  logic [TOKW-1:0] disp_token,
    input  logic [LATW-1:0] disp_lat,
    input  logic            disp_partial,
    input  logic            issue,
    input  logic            tick,
    input  logic            note,
    input  logic            note_ok,
    input  logic [CW-1:0]   older_left,
    input  logic            rd_all_nxt,
    output stage_e          stage_o,
    output logic [LATW-1:0] exec_left_o,
    output logic [LATW-1:0] lat_o,
    output logic [TOKW-1:0] token_o,
    output logic            err_o,
    output logic            rd_load,
    output logic            rd_note,
    output logic            rd_tick,
    output logic            wr_load,
    output logic            wr_dec
);
    stage_e          stage_q, stage_n;
    logic [LATW-1:0] exec_q, exec_n;
    logic [LATW-1:0] lat_q;
    logic            part_q;
    logic [TOKW-1:0] tok_q;
    logic            err_q, err_n;

    logic multi;
    logic acc_disp, acc_issue, acc_note, acc_tick;
    logic pok_disp, pok_held;

    function automatic logic partial_ok(input logic part, input logic [CW-1:0] older,
                                        input logic [LATW-1:0] lat);
        partial_ok = !part || ((older != '1) && (older < CW'(lat)));
    endfunction

    always_comb begin
        multi     = ($countones({disp, issue, tick, note}) > 1);
        acc_disp  = disp  && !multi && (stage_q == ST_EMPTY);
        acc_issue = issue && !multi && (stage_q == ST_READY);
        acc_note  = note  && !multi && (stage_q == ST_WAITING) && note_ok;
        acc_tick  = tick  && !multi;
        err_n     = err_q || multi
                  || (disp  && stage_q != ST_EMPTY)
                  || (issue && stage_q != ST_READY)
                  || (note  && !(stage_q == ST_WAITING && note_ok));
        pok_disp  = partial_ok(disp_partial, older_left, disp_lat);
        pok_held  = partial_ok(part_q, older_left, lat_q);
    end

    // next stage and execution count
    always_comb begin
        stage_n = stage_q;
        exec_n  = exec_q;
        unique case (stage_q)
            ST_EMPTY: begin
                if (acc_disp)
                    stage_n = (rd_all_nxt && pok_disp) ? ST_READY : ST_WAITING;
            end
            ST_WAITING: begin
                if (acc_tick && rd_all_nxt && pok_held)
                    stage_n = ST_READY;
            end
            ST_READY: begin
                if (acc_issue) begin
                    exec_n  = lat_q;
                    stage_n = (lat_q == '0) ? ST_DONE : ST_RUNNING;
                end
            end
            ST_RUNNING: begin
                if (acc_tick) begin
                    exec_n = exec_q - 1'b1;
                    if (exec_q == LATW'(1))
                        stage_n = ST_DONE;
                end
            end
            ST_DONE: begin
                stage_n = ST_DONE;
            end
            default: begin
                stage_n = ST_EMPTY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= ST_EMPTY;
            exec_q  <= '0;
            lat_q   <= '0;
            part_q  <= 1'b0;
            tok_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            stage_q <= stage_n;
            exec_q  <= exec_n;
            err_q   <= err_n;
            if (acc_disp) begin
                lat_q  <= disp_lat;
                part_q <= disp_partial;
                tok_q  <= disp_token;
            end
        end
    end

    // outputs
    always_comb begin
        stage_o     = stage_q;
        exec_left_o = exec_q;
        lat_o       = lat_q;
        token_o     = tok_q;
        err_o       = err_q;
        rd_load     = acc_disp;
        rd_note     = acc_note;
        rd_tick     = acc_tick && (stage_q == ST_WAITING);
        wr_load     = acc_issue;
        wr_dec      = acc_tick && (stage_q == ST_RUNNING);
    end

    // R9: protocol error is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    // R10: the cycle that raises the error applies no transition
    p_err_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (stage_q == $past(stage_q)));

    // R8: completion is final until reset
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_DONE) |=> (stage_q == ST_DONE));

    // R2: waiting is entered only from empty
    p_wait_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q == ST_WAITING) |-> ($past(stage_q) == ST_EMPTY || $past(stage_q) == ST_WAITING));

endmodule

// File: rtl/op_wakeup_tracker.sv
module op_wakeup_tracker
    import owt_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int LATW = 8,
    parameter int CW   = 16,
    parameter int PCW  = 3,
    parameter int TOKW = 6,
    localparam int SLOTW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid,
    input  logic [TOKW-1:0]      disp_token,
    input  logic [LATW-1:0]      disp_lat,
    input  logic                 disp_partial,
    input  logic [NSRC*PCW-1:0]  disp_pend,
    input  logic [CW-1:0]        older_left,
    input  logic                 issue_valid,
    input  logic                 tick,
    input  logic                 note_valid,
    input  logic [SLOTW-1:0]     note_slot,
    input  logic [LATW-1:0]      note_lat,
    input  logic [LATW-1:0]      note_adv,
    output logic [2:0]           stage,
    output logic                 ready,
    output logic [LATW-1:0]      exec_left,
    output logic [CW-1:0]        wr_left,
    output logic [TOKW-1:0]      token,
    output logic [NSRC-1:0]      src_ready,
    output logic                 proto_err
);
    stage_e              stage_s;
    logic [LATW-1:0]     lat_s;
    logic [NSRC-1:0]     pend_nz;
    logic [NSRC-1:0]     rdy_nxt;
    logic                note_ok;
    logic                rd_load, rd_note, rd_tick, wr_load, wr_dec;
    logic signed [CW-1:0] wr_s;

    always_comb begin
        note_ok = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (note_slot == SLOTW'(s))
                note_ok = pend_nz[s];
        end
    end

    owt_stage_ctl #(.LATW(LATW), .CW(CW), .TOKW(TOKW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .disp        (disp_valid),
        .disp_token  (disp_token),
        .disp_lat    (disp_lat),
        .disp_partial(disp_partial),
        .issue       (issue_valid),
        .tick        (tick),
        .note        (note_valid),
        .note_ok     (note_ok),
        .older_left  (older_left),
        .rd_all_nxt  (&rdy_nxt),
        .stage_o     (stage_s),
        .exec_left_o (exec_left),
        .lat_o       (lat_s),
        .token_o     (token),
        .err_o       (proto_err),
        .rd_load     (rd_load),
        .rd_note     (rd_note),
        .rd_tick     (rd_tick),
        .wr_load     (wr_load),
        .wr_dec      (wr_dec)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        owt_read_slot #(.LATW(LATW), .PCW(PCW)) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (rd_load),
            .load_pend(disp_pend[s*PCW +: PCW]),
            .note     (rd_note && (note_slot == SLOTW'(s))),
            .note_lat (note_lat),
            .note_adv (note_adv),
            .tick     (rd_tick),
            .pend_nz  (pend_nz[s]),
            .rdy_q    (src_ready[s]),
            .rdy_nxt  (rdy_nxt[s])
        );
    end

    owt_write_ctr #(.LATW(LATW), .CW(CW)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wr_load),
        .load_val(lat_s),
        .dec     (wr_dec),
        .wr_q    (wr_s)
    );

    assign stage   = stage_s;
    assign ready   = (stage_s == ST_READY);
    assign wr_left = wr_s;

    // R11: the ready stage is only held with every source woken
    p_ready_reads_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_s == ST_READY) |-> (&src_ready));

    // R6: once issued, write counter and execution counter agree
    p_run_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_s == ST_RUNNING || stage_s == ST_DONE) |-> (wr_left == CW'(exec_left)));

endmodule

// File: tb/sim_op_wakeup_tracker.sv
module sim_op_wakeup_tracker;
    localparam int NSRC = 2;
    localparam int LATW = 8;
    localparam int CW   = 16;
    localparam int PCW  = 3;
    localparam int TOKW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 0, disp_partial = 0, issue_valid = 0, tick = 0, note_valid = 0;
    logic [TOKW-1:0] disp_token = '0;
    logic [LATW-1:0] disp_lat = '0, note_lat = '0, note_adv = '0;
    logic [NSRC*PCW-1:0] disp_pend = '0;
    logic [CW-1:0] older_left = '1;
    logic [0:0] note_slot = '0;
    logic [2:0] stage;
    logic ready, proto_err;
    logic [LATW-1:0] exec_left;
    logic [CW-1:0] wr_left;
    logic [TOKW-1:0] token;
    logic [NSRC-1:0] src_ready;

    int checks = 0;
    int errs = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    op_wakeup_tracker #(.NSRC(NSRC), .LATW(LATW), .CW(CW), .PCW(PCW), .TOKW(TOKW)) u0 (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_token(disp_token),
        .disp_lat(disp_lat), .disp_partial(disp_partial), .disp_pend(disp_pend),
        .older_left(older_left), .issue_valid(issue_valid), .tick(tick),
        .note_valid(note_valid), .note_slot(note_slot), .note_lat(note_lat),
        .note_adv(note_adv), .stage(stage), .ready(ready), .exec_left(exec_left),
        .wr_left(wr_left), .token(token), .src_ready(src_ready), .proto_err(proto_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        older_left = '1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic dispatch(input int tok, input int lat, input bit part, input int p0, input int p1);
        @(negedge clk);
        disp_valid = 1; disp_token = TOKW'(tok); disp_lat = LATW'(lat);
        disp_partial = part; disp_pend = {PCW'(p1), PCW'(p0)};
        @(negedge clk);
        disp_valid = 0;
    endtask

    task automatic notify(input int slot, input int lat, input int adv);
        @(negedge clk);
        note_valid = 1; note_slot = 1'(slot); note_lat = LATW'(lat); note_adv = LATW'(adv);
        @(negedge clk);
        note_valid = 0;
    endtask

    task automatic do_issue();
        @(negedge clk);
        issue_valid = 1;
        @(negedge clk);
        issue_valid = 0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick = 1;
            @(negedge clk);
            tick = 0;
        end
    endtask

    // vector table: producer latency, read advance
    localparam int NV = 8;
    localparam int V_LAT [NV] = '{5, 5, 3, 0, 4, 1, 7, 2};
    localparam int V_ADV [NV] = '{0, 2, 5, 0, -2, 0, 7, -3};

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check("R1 stage", stage, 0);
        check("R1 ready", ready, 0);
        check("R1 exec_left", exec_left, 0);
        check("R1 wr_left", wr_left, 16'hFFFF);
        check("R1 src_ready", src_ready, 0);
        check("R1 proto_err", proto_err, 0);

        // R3 vector walk: one pending write on slot 0
        for (int v = 0; v < NV; v++) begin
            int d, n;
            d = V_LAT[v] - V_ADV[v];
            if (d < 0) d = 0;
            n = (d < 1) ? 1 : d;
            do_reset();
            dispatch(v, 3, 0, 1, 0);
            check("R2 waiting", stage, 1);
            notify(0, V_LAT[v], V_ADV[v]);
            check("R3 src ready after note", src_ready[0], (d == 0) ? 1 : 0);
            if (n > 1) begin
                ticks(n - 1);
                check("R3 not early", stage, 1);
            end
            ticks(1);
            check("R3 ready stage", stage, 2);
            check("R11 ready flag", ready, 1);
        end

        // R2 immediate ready, R6/R7 execution, R8 ignored ticks
        do_reset();
        dispatch(42, 3, 0, 0, 0);
        check("R2 ready at dispatch", stage, 2);
        check("R2 token", token, 42);
        check("R2 src_ready", src_ready, 3);
        ticks(1);
        check("R8 tick in ready", stage, 2);
        do_issue();
        check("R6 running", stage, 3);
        check("R6 exec_left", exec_left, 3);
        check("R6 wr_left", wr_left, 3);
        check("R11 ready low", ready, 0);
        ticks(2);
        check("R7 exec_left", exec_left, 1);
        check("R7 wr_left", wr_left, 1);
        check("R7 still running", stage, 3);
        ticks(1);
        check("R7 done", stage, 4);
        check("R7 wr zero", wr_left, 0);
        ticks(1);
        check("R8 done exec", exec_left, 0);
        check("R8 done wr", wr_left, 0);
        check("R8 done stage", stage, 4);
        check("R8 no err", proto_err, 0);

        // R6 zero latency
        do_reset();
        dispatch(1, 0, 0, 0, 0);
        do_issue();
        check("R6 zero lat stage", stage, 4);
        check("R6 zero lat wr", wr_left, 0);

        // R4 several producers, max kept
        do_reset();
        dispatch(2, 2, 0, 3, 1);
        notify(0, 2, 0);
        notify(0, 5, 0);
        notify(1, 1, 0);
        check("R4 waiting", stage, 1);
        check("R4 src still pending", src_ready, 0);
        notify(0, 3, 0);
        check("R4 slot0 count nonzero", src_ready[0], 0);
        ticks(4);
        check("R4 not yet", stage, 1);
        check("R4 slot1 ready", src_ready[1], 1);
        ticks(1);
        check("R4 ready after max", stage, 2);

        // R4 ticks shrink the accumulated delay
        do_reset();
        dispatch(3, 2, 0, 2, 0);
        notify(0, 4, 0);
        ticks(2);
        notify(0, 1, 0);
        ticks(1);
        check("R4 tick-pending wait", stage, 1);
        ticks(1);
        check("R4 tick-pending ready", stage, 2);

        // R5 partial write gate
        do_reset();
        dispatch(4, 3, 1, 0, 0);
        check("R5 unknown blocks", stage, 1);
        @(negedge clk); older_left = 16'd3;
        ticks(1);
        check("R5 equal blocks", stage, 1);
        @(negedge clk); older_left = -16'sd3;
        ticks(1);
        check("R5 negative blocks", stage, 1);
        @(negedge clk); older_left = 16'd2;
        ticks(1);
        check("R5 below passes", stage, 2);
        do_reset();
        @(negedge clk); older_left = 16'd0;
        dispatch(5, 3, 1, 0, 0);
        check("R5 at dispatch", stage, 2);

        // R9 protocol errors
        do_reset();
        do_issue();
        check("R9 issue in empty err", proto_err, 1);
        check("R9 issue in empty stage", stage, 0);
        ticks(1);
        check("R9 sticky", proto_err, 1);
        do_reset();
        dispatch(6, 2, 0, 0, 1);
        do_issue();
        check("R9 issue waiting err", proto_err, 1);
        check("R9 issue waiting stage", stage, 1);
        do_reset();
        dispatch(7, 2, 0, 1, 0);
        notify(1, 9, 0);
        check("R9 note no pending err", proto_err, 1);
        check("R9 slot1 untouched", src_ready[1], 1);
        notify(0, 0, 0);
        ticks(1);
        check("R9 slot0 intact", stage, 2);
        do_reset();
        dispatch(8, 2, 0, 0, 0);
        dispatch(9, 2, 0, 0, 0);
        check("R9 redispatch err", proto_err, 1);
        check("R9 token kept", token, 8);

        // R10 simultaneous events
        do_reset();
        @(negedge clk);
        disp_valid = 1; tick = 1; disp_pend = '0; disp_token = 6'd11;
        @(negedge clk);
        disp_valid = 0; tick = 0;
        check("R10 err", proto_err, 1);
        check("R10 nothing applied", stage, 0);
        check("R10 token not stored", token, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule